// File: doc/BRIEF.md
# Processor Reset, Interrupt and Watchdog Controller

This block produces the active-low processor reset and two active-low interrupt lines for an embedded processor. Reset comes from three places: a backplane reset request, a debounced manual or external reset switch, and an internal watchdog timer. Once every source has let go, reset stays asserted for a fixed minimum stretch. Interrupt line A carries a periodic tick that is low for one fifth of each period. This tick sets the processor's service rhythm. Interrupt line B carries two external active-low requests ORed together.

Both interrupt lines also act as boot-mode straps. While reset is asserted, line A is held low and line B is held high, so the processor samples the boot mode that starts execution from external non-volatile memory. The watchdog restarts on every read strobe whose address matches one fixed kick address. If no kick arrives within the timeout, the watchdog fires a reset. A static enable input turns the watchdog off completely. The watchdog counter is held clear during reset, so a freshly booted processor always gets a full timeout.

The reset sequencer is a three-state machine. ST_HOLD means a source is active. ST_STRETCH counts out the minimum hold time. ST_RUN means the processor is released. Its transitions are:
- any state moves to ST_HOLD on any active source;
- ST_HOLD moves to ST_STRETCH when all sources are quiet;
- ST_STRETCH moves to ST_RUN after the stretch count.

Top module: `rstirq_ctrl`

## Requirements
- R1: `cpu_rst_n` goes low on the clock edge after any of these is seen: `bp_rst_n` low, `sw_rst_n` low, or the watchdog expiring.
- R2: After the last reset source is released, `cpu_rst_n` stays low for exactly STRETCH (default 16) further clock edges. This also applies after the power-on reset `arst_n` is released.
- R3: `irqa_n` is high only when `cpu_rst_n` is high and the tick is high. It is low throughout reset.
- R4: `irqb_n` is high throughout reset, which is the boot-mode strap value.
- R5: While `cpu_rst_n` is high, `irqb_n` is the AND of `pulse_n` and `ext_irq_n`, so either input going low raises the interrupt.
- R6: The tick has a period of TICK_CYCLES clocks and is low for TICK_CYCLES/5 clocks of each period.
- R7: With `wdog_en` high, once the last kick has been applied, `cpu_rst_n` stays high for exactly WD_CYCLES clock edges and then goes low.
- R8: The watchdog restarts only when `kick_rd` is high and `kick_addr` equals KICK_ADDR (default 16'hFFF7). A read of any other address, or the address without the strobe, has no effect.
- R9: With `wdog_en` low, the watchdog never causes a reset, however long it goes without a kick.
- R10: The watchdog count is held clear while `cpu_rst_n` is low. After a watchdog-caused reset, the next expiry comes WD_CYCLES+1 edges after `cpu_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Power-on reset, asynchronous, active low |
| bp_rst_n | input | 1 | Backplane reset request, active low |
| sw_rst_n | input | 1 | Debounced manual/external reset switch, active low |
| wdog_en | input | 1 | Watchdog enable strap |
| kick_rd | input | 1 | Processor read strobe |
| kick_addr | input | ADDR_W | Processor read address |
| pulse_n | input | 1 | Timing-board interrupt request, active low |
| ext_irq_n | input | 1 | Bussed external interrupt request, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| irqa_n | output | 1 | Interrupt A / boot strap: gated tick |
| irqb_n | output | 1 | Interrupt B / boot strap: held high in reset |

## Verification
The bench measures the reset stretch after power-on, after a switch release, after a backplane release and after a watchdog trip. A sequencer that counted one edge too many or too few would change the measured low length. It times the watchdog from the last valid kick while driving near-miss reads, meaning a wrong address or a missing strobe. A decoder that matched loosely would push the expiry back. A counter left running through reset would make the second expiry come early. Random interrupt input pairs are checked against line B while running. The tick duty is counted over whole periods, so an off-by-one low phase shows up directly.

// File: rtl/rstirq_pkg.sv
package rstirq_pkg;
    typedef enum logic [1:0] {
        ST_HOLD,
        ST_STRETCH,
        ST_RUN
    } rst_state_e;
endpackage

// File: rtl/rstirq_tick.sv
module rstirq_tick #(
    parameter int unsigned TICK_CYCLES = 50000
) (
    input  logic clk,
    input  logic arst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(TICK_CYCLES);
    localparam int unsigned LOW_CYCLES = TICK_CYCLES / 5;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
    localparam logic [CW-1:0] LOW_END = CW'(LOW_CYCLES);

    logic [CW-1:0] phase_q;
    logic [CW-1:0] phase_d;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            phase_q <= LAST;
            tick    <= 1'b1;
        end else begin
            phase_q <= phase_d;
            tick    <= (phase_d >= LOW_END);
        end
    end
endmodule

// File: rtl/rstirq_wdog.sv
module rstirq_wdog #(
    parameter int unsigned WD_CYCLES = 500000,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 16'hFFF7
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              en,
    input  logic              hold,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              trip
);
    localparam int unsigned CW = $clog2(WD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WD_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          kick;

    always_comb begin
        kick = rd && (addr == KICK_ADDR);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (hold || kick || !en) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        trip = en && (cnt_q == LIMIT);
    end
endmodule

// File: rtl/rstirq_seq.sv
module rstirq_seq
    import rstirq_pkg::*;
#(
    parameter int unsigned STRETCH = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic src,
    output logic rst_n
);
    localparam int unsigned SW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [SW-1:0] SLAST = SW'(STRETCH - 1);

    rst_state_e    state_q;
    rst_state_e    state_d;
    logic [SW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    if (!src) state_d = ST_STRETCH;
            ST_STRETCH: if (src) state_d = ST_HOLD;
                        else if (cnt_q == SLAST) state_d = ST_RUN;
            ST_RUN:     if (src) state_d = ST_HOLD;
            default:    state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_STRETCH) ? cnt_q + 1'b1 : '0;
        end
    end

    always_comb begin
        rst_n = (state_q == ST_RUN);
    end
endmodule

// File: rtl/rstirq_ctrl.sv
module rstirq_ctrl #(
    parameter int unsigned TICK_CYCLES = 50000,
    parameter int unsigned WD_CYCLES   = 500000,
    parameter int unsigned STRETCH     = 16,
    parameter int unsigned ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 16'hFFF7
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              bp_rst_n,
    input  logic              sw_rst_n,
    input  logic              wdog_en,
    input  logic              kick_rd,
    input  logic [ADDR_W-1:0] kick_addr,
    input  logic              pulse_n,
    input  logic              ext_irq_n,
    output logic              cpu_rst_n,
    output logic              irqa_n,
    output logic              irqb_n
);
    logic tick;
    logic wd_trip;
    logic rst_src;

    rstirq_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk(clk), .arst_n(arst_n), .tick(tick)
    );

    rstirq_wdog #(.WD_CYCLES(WD_CYCLES), .ADDR_W(ADDR_W), .KICK_ADDR(KICK_ADDR)) u_wdog (
        .clk(clk), .arst_n(arst_n), .en(wdog_en), .hold(!cpu_rst_n),
        .rd(kick_rd), .addr(kick_addr), .trip(wd_trip)
    );

    always_comb begin
        rst_src = wd_trip || !bp_rst_n || !sw_rst_n;
    end

    rstirq_seq #(.STRETCH(STRETCH)) u_seq (
        .clk(clk), .arst_n(arst_n), .src(rst_src), .rst_n(cpu_rst_n)
    );

    always_comb begin
        irqa_n = cpu_rst_n && tick;
        irqb_n = !cpu_rst_n || (pulse_n && ext_irq_n);
    end
endmodule

// File: rtl/rstirq_ctrl_chk.sv
module rstirq_ctrl_chk #(
    parameter int unsigned STRETCH = 16
) (
    input logic clk,
    input logic arst_n,
    input logic bp_rst_n,
    input logic sw_rst_n,
    input logic wdog_en,
    input logic pulse_n,
    input logic ext_irq_n,
    input logic wd_trip,
    input logic cpu_rst_n,
    input logic irqa_n,
    input logic irqb_n
);
    logic [7:0] quiet_q;
    logic       any_src;

    always_comb any_src = wd_trip || !bp_rst_n || !sw_rst_n;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) quiet_q <= '0;
        else if (any_src) quiet_q <= '0;
        else if (quiet_q != 8'hFF) quiet_q <= quiet_q + 1'b1;
    end

    p_src_resets_r1: assert property (@(posedge clk) disable iff (!arst_n)
        any_src |=> !cpu_rst_n);

    p_min_stretch_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(cpu_rst_n) |-> (quiet_q >= 8'(STRETCH)));

    p_irqa_gated_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !cpu_rst_n |-> !irqa_n);

    p_irqb_strap_r4: assert property (@(posedge clk) disable iff (!arst_n)
        !cpu_rst_n |-> irqb_n);

    p_irqb_req_r5: assert property (@(posedge clk) disable iff (!arst_n)
        (cpu_rst_n && (!pulse_n || !ext_irq_n)) |-> !irqb_n);

    p_wd_off_r9: assert property (@(posedge clk) disable iff (!arst_n)
        !wdog_en |-> !wd_trip);
endmodule

bind rstirq_ctrl rstirq_ctrl_chk #(.STRETCH(STRETCH)) i_chk (
    .clk(clk), .arst_n(arst_n), .bp_rst_n(bp_rst_n), .sw_rst_n(sw_rst_n),
    .wdog_en(wdog_en), .pulse_n(pulse_n), .ext_irq_n(ext_irq_n),
    .wd_trip(wd_trip), .cpu_rst_n(cpu_rst_n), .irqa_n(irqa_n), .irqb_n(irqb_n)
);

// File: tb/test_rstirq_ctrl.sv
module test_rstirq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 20;
    localparam int WD = 200;
    localparam int STR = 16;
    localparam logic [15:0] KADDR = 16'hFFF7;

    logic clk = 1'b0;
    logic arst_n, bp_rst_n, sw_rst_n, wdog_en, kick_rd, pulse_n, ext_irq_n;
    logic [15:0] kick_addr;
    logic cpu_rst_n, irqa_n, irqb_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstirq_ctrl #(.TICK_CYCLES(TICK), .WD_CYCLES(WD), .STRETCH(STR),
                  .ADDR_W(16), .KICK_ADDR(KADDR)) i_rstirq_ctrl (
        .clk(clk), .arst_n(arst_n), .bp_rst_n(bp_rst_n), .sw_rst_n(sw_rst_n),
        .wdog_en(wdog_en), .kick_rd(kick_rd), .kick_addr(kick_addr),
        .pulse_n(pulse_n), .ext_irq_n(ext_irq_n),
        .cpu_rst_n(cpu_rst_n), .irqa_n(irqa_n), .irqb_n(irqb_n)
    );

    function automatic int exp_irqb(input logic rstn, input logic p, input logic e);
        return (!rstn || (p && e)) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (cpu_rst_n) break;
            n++;
        end
    endtask

    task automatic count_high(input bit noisy, output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!cpu_rst_n) break;
            n++;
            if (noisy) begin
                kick_rd   = (i % 2 == 0);
                kick_addr = (i % 2 == 0) ? (KADDR ^ (16'h1 << (i % 16))) : KADDR;
            end
        end
        kick_rd = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk);
        kick_rd = 1'b1;
        kick_addr = KADDR;
        @(negedge clk);
        kick_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int r;
        int unsigned seed;
        bit alive;
        seed = $urandom(32'd4242);
        arst_n = 1'b0; bp_rst_n = 1'b1; sw_rst_n = 1'b1; wdog_en = 1'b0;
        kick_rd = 1'b0; kick_addr = '0; pulse_n = 1'b1; ext_irq_n = 1'b1;
        #(CLK_PERIOD * 3 + 1);
        chk(cpu_rst_n == 1'b0, "R2 reset low at power-on", cpu_rst_n, 0);
        chk(irqa_n == 1'b0, "R3 irqa low in reset", irqa_n, 0);
        chk(irqb_n == 1'b1, "R4 irqb strap high in reset", irqb_n, 1);
        @(negedge clk);
        arst_n = 1'b1;
        count_low(n);
        chk(n == STR, "R2 power-on stretch", n, STR);

        // R6 tick duty and period
        n = 0;
        for (int i = 0; i < 3 * TICK; i++) begin
            @(negedge clk);
            if (!irqa_n) n++;
        end
        chk(n == 3 * (TICK / 5), "R6 tick low count over 3 periods", n, 3 * (TICK / 5));
        while (irqa_n) @(negedge clk);
        while (!irqa_n) @(negedge clk);
        n = 0;
        while (irqa_n) begin @(negedge clk); n++; end
        chk(n == TICK - TICK / 5, "R6 tick high length", n, TICK - TICK / 5);

        // R5 random interrupt inputs while running
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            r = $urandom;
            pulse_n = r[0];
            ext_irq_n = r[1];
            #1;
            chk(int'(irqb_n) == exp_irqb(cpu_rst_n, pulse_n, ext_irq_n),
                "R5 irqb follows requests", irqb_n, exp_irqb(cpu_rst_n, pulse_n, ext_irq_n));
        end
        pulse_n = 1'b1; ext_irq_n = 1'b1;

        // R1/R2 switch reset
        @(negedge clk);
        sw_rst_n = 1'b0;
        @(negedge clk);
        chk(cpu_rst_n == 1'b0, "R1 switch asserts reset", cpu_rst_n, 0);
        pulse_n = 1'b0;
        #1;
        chk(irqb_n == 1'b1, "R4 strap overrides request", irqb_n, 1);
        pulse_n = 1'b1;
        repeat (2 + ($urandom % 5)) @(negedge clk);
        sw_rst_n = 1'b1;
        count_low(n);
        chk(n == STR, "R2 stretch after switch", n, STR);

        // R1/R2 backplane reset
        @(negedge clk);
        bp_rst_n = 1'b0;
        @(negedge clk);
        chk(cpu_rst_n == 1'b0, "R1 backplane asserts reset", cpu_rst_n, 0);
        bp_rst_n = 1'b1;
        count_low(n);
        chk(n == STR, "R2 stretch after backplane", n, STR);

        // R8 regular kicks keep it alive
        wdog_en = 1'b1;
        alive = 1'b1;
        for (int k = 0; k < 15; k++) begin
            kick();
            r = 5 + ($urandom % (WD - 40));
            for (int j = 0; j < r; j++) begin
                @(negedge clk);
                if (!cpu_rst_n) alive = 1'b0;
            end
        end
        chk(alive, "R8 valid kicks prevent expiry", alive, 1);

        // R7/R8 expiry from last kick with near-miss reads
        kick();
        count_high(1'b1, n);
        chk(n == WD, "R7 R8 expiry time from last kick", n, WD);
        count_low(n);
        chk(n >= STR, "R2 stretch after watchdog", n, STR);
        // R10 counter cleared during reset
        count_high(1'b0, n);
        n = n + 1;
        chk(n == WD + 1, "R10 full timeout after watchdog reset", n, WD + 1);
        count_low(n);

        // R9 disabled watchdog never trips
        wdog_en = 1'b0;
        @(negedge clk);
        alive = 1'b1;
        for (int j = 0; j < 3 * WD; j++) begin
            @(negedge clk);
            if (!cpu_rst_n) alive = 1'b0;
        end
        chk(alive, "R9 disabled watchdog", alive, 1);
        chk(irqb_n == 1'b1, "R5 idle irqb high", irqb_n, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule